// File: doc/BRIEF.md
# Multi-cycle microcoded program sequencer

This block runs a short fixed program whose entries sit in a constant table. Each entry holds an opcode and a data field that gives the target of a jump. Each opcode takes a set number of clocks. A program counter selects the current entry. A one-hot cycle register counts the clocks spent on that entry. When the entry has used its clocks, the counter moves on by one address, or it loads the target if the entry is a jump that is taken.

For every user opcode, and for every clock index that opcode owns, the block raises a registered one-clock action pulse. A datapath outside the block turns those pulses into work. A separate run controller restarts the program by holding a load-begin command for two clocks. It parks the program at its end address by holding a load-end command for two clocks.

Top module: `uprog_sequencer`

## Requirements
- R1: While reset is held and just after it is released, pc_o reads the end address 9 and act_o is all zero.
- R2: Opcode encoding is fixed. Opcode 0 is a no-operation that falls through after one cycle. Opcode 1 is an unconditional jump. Opcodes 2, 3 and 4 are user opcodes U0, U1 and U2, which take 1, 2 and 3 cycles. Opcodes 5 and 6 are conditional jumps on cond_i[0] and cond_i[1]. The begin address is 0. The end address equals the number of program lines (9). The entry at the end address jumps to itself, so pc_o stays at 9 once it arrives there.
- R3: An instruction of n cycles keeps pc_o at its address for n+1 clocks and then advances it by one. No-operation and the jump opcodes count as n = 1.
- R4: Bit u*3+c of act_o belongs to user opcode u (u = opcode-2) and cycle c, where c is less than that opcode's cycle count. The bit is high for exactly one clock, in clock c+1 after pc_o first shows the instruction (the entry clock is clock 0). At most one bit of act_o is high in any clock.
- R5: An unconditional jump occupies pc_o for two clocks and then loads its target. The load takes precedence over the increment that falls due on the same edge.
- R6: A conditional jump is taken when its condition bit is high while the instruction is held. Otherwise it falls through to the next address, like a no-operation.
- R7: When load_begin_i is held for two clocks, pc_o reads 0 from the first sampling edge onward. Cycle 0 of address 0 starts at the first edge that samples load_begin_i low.
- R8: Program counter priority runs load-begin, then load-end, then taken jump, then increment. When both commands are held together, the program restarts at address 0.
- R9: When load_end_i is held for two clocks, pc_o reads 9 from the first sampling edge onward. It stays there with no action pulses until the next load-begin.
- R10: No action pulse is produced on an edge that samples either command high, nor on the edge that follows an edge sampling load_begin_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_begin_i | input | 1 | Restart command from the run controller, held two clocks |
| load_end_i | input | 1 | Park command from the run controller, held two clocks |
| cond_i | input | 2 | Condition inputs for the conditional jump opcodes |
| pc_o | output | 4 | Current program counter |
| act_o | output | 9 | One-clock action pulses, one bit per user opcode and cycle |

## Verification
On every jump, two updates fall due on the same edge: the increment request, because the jump's one-cycle count has run out, and the qualified jump. The program places a jump whose target differs from the next address, and conditional jumps with both outcomes. Each jump is judged by the address pc_o moves to and by how long the jump held pc_o. The two run-controller commands are also held together in the same clocks, and the bench expects a restart at address 0 with no action pulse. A cycle-accurate reference model follows the whole trace.

// File: rtl/uprog_pkg.sv
package uprog_pkg;

  localparam int PROG_LINES = 9;
  localparam int NUM_USER   = 3;
  localparam int NUM_COND   = 2;
  localparam int MAX_CYC    = 3;
  localparam int DATA_MIN_W = 3;

  localparam int OP_NOP   = 0;
  localparam int OP_JMP   = 1;
  localparam int OP_USER0 = 2;
  localparam int OP_COND0 = OP_USER0 + NUM_USER;
  localparam int NUM_OPS  = OP_COND0 + NUM_COND;

  localparam int OP_W   = $clog2(NUM_OPS);
  localparam int PC_W   = $clog2(PROG_LINES + 1);
  localparam int DATA_W = (PC_W > DATA_MIN_W) ? PC_W : DATA_MIN_W;
  localparam int CY_W   = MAX_CYC + 1;
  localparam int ACT_W  = NUM_USER * MAX_CYC;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [DATA_W-1:0] data;
  } instr_t;

  // cycle count of each user opcode
  function automatic int user_cycles(input int u);
    case (u)
      0:       return 1;
      1:       return 2;
      default: return 3;
    endcase
  endfunction

  // one-hot mask of the last cycle index of an opcode
  function automatic logic [CY_W-1:0] cyc_mask(input logic [OP_W-1:0] op);
    int o;
    o = int'(op);
    if (o >= OP_USER0 && o < OP_COND0)
      return CY_W'(1) << (user_cycles(o - OP_USER0) - 1);
    return CY_W'(1);
  endfunction

  // fixed program; the end address and anything past it jump to the end
  function automatic instr_t prog_word(input int addr);
    instr_t w;
    w.op   = OP_W'(OP_JMP);
    w.data = DATA_W'(PROG_LINES);
    case (addr)
      0: begin w.op = OP_W'(OP_USER0);     w.data = '0;        end
      1: begin w.op = OP_W'(OP_USER0 + 1); w.data = '0;        end
      2: begin w.op = OP_W'(OP_COND0);     w.data = DATA_W'(5); end
      3: begin w.op = OP_W'(OP_USER0 + 2); w.data = '0;        end
      4: begin w.op = OP_W'(OP_JMP);       w.data = DATA_W'(7); end
      5: begin w.op = OP_W'(OP_USER0 + 2); w.data = '0;        end
      6: begin w.op = OP_W'(OP_COND0 + 1); w.data = DATA_W'(1); end
      7: begin w.op = OP_W'(OP_USER0 + 1); w.data = '0;        end
      8: begin w.op = OP_W'(OP_NOP);       w.data = '0;        end
      default: ;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/uprog_decode.sv
module uprog_decode
  import uprog_pkg::*;
#(
  parameter int PCW = PC_W,
  parameter int NC  = NUM_COND
) (
  input  logic [PCW-1:0]    pc_i,
  input  logic [NC-1:0]     cond_i,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] data_o,
  output logic [CY_W-1:0]   mask_o,
  output logic              jump_req_o
);

  instr_t word;

  always_comb begin
    word       = prog_word(int'(pc_i));
    op_o       = word.op;
    data_o     = word.data;
    mask_o     = cyc_mask(word.op);
    jump_req_o = (word.op == OP_W'(OP_JMP));
    for (int k = 0; k < NC; k++) begin
      if (word.op == OP_W'(OP_COND0 + k) && cond_i[k]) jump_req_o = 1'b1;
    end
  end

endmodule

// File: rtl/uprog_cycle_ctr.sv
module uprog_cycle_ctr
  import uprog_pkg::*;
#(
  parameter int CYW = CY_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reload_i,
  output logic [CYW-1:0] cy_o
);

  logic [CYW-1:0] cy_q, cy_d;
  logic           cy_en;

  always_comb begin
    cy_en = 1'b1;
    if (reload_i || cy_q == '0) cy_d = CYW'(1);
    else                        cy_d = cy_q << 1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cy_q <= CYW'(1);
    else if (cy_en) cy_q <= cy_d;
  end

  assign cy_o = cy_q;

  // R3
  reload_to_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> (cy_q == CYW'(1)));

endmodule

// File: rtl/uprog_pc_ctl.sv
module uprog_pc_ctl
  import uprog_pkg::*;
#(
  parameter int PCW   = PC_W,
  parameter int DW    = DATA_W,
  parameter int CYW   = CY_W,
  parameter int LINES = PROG_LINES
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_begin_i,
  input  logic           load_end_i,
  input  logic           jump_req_i,
  input  logic [CYW-1:0] cy_i,
  input  logic [CYW-1:0] mask_i,
  input  logic [DW-1:0]  data_i,
  output logic [PCW-1:0] pc_o,
  output logic           take_jump_o,
  output logic           inc_o,
  output logic           begin_d1_o
);

  localparam logic [PCW-1:0] END_PC = PCW'(LINES);

  logic [PCW-1:0] pc_q, pc_d;
  logic           pc_en;
  logic           inc_q, inc_d;
  logic           jmp_q, jmp_d;
  logic           cy0_q, cy0_d;
  logic           lbd_q;
  logic           take;

  always_comb begin
    inc_d = (cy_i == mask_i) && !lbd_q;
    jmp_d = jump_req_i;
    cy0_d = cy_i[0] && !lbd_q;
    take  = jmp_q && cy0_q;
    pc_en = load_begin_i || load_end_i || take || inc_q;
    if (load_begin_i)    pc_d = '0;
    else if (load_end_i) pc_d = END_PC;
    else if (take)       pc_d = data_i[PCW-1:0];
    else                 pc_d = pc_q + PCW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= END_PC;
      inc_q <= 1'b0;
      jmp_q <= 1'b0;
      cy0_q <= 1'b0;
      lbd_q <= 1'b0;
    end else begin
      inc_q <= inc_d;
      jmp_q <= jmp_d;
      cy0_q <= cy0_d;
      lbd_q <= load_begin_i;
      if (pc_en) pc_q <= pc_d;
    end
  end

  assign pc_o        = pc_q;
  assign take_jump_o = take;
  assign inc_o       = inc_q;
  assign begin_d1_o  = lbd_q;

  // R7
  begin_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_begin_i |=> (pc_q == '0));

  // R9
  end_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_end_i && !load_begin_i) |=> (pc_q == END_PC));

  // R5
  jump_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !load_begin_i && !load_end_i) |=> (pc_q == $past(data_i[PCW-1:0])));

endmodule

// File: rtl/uprog_action_dec.sv
module uprog_action_dec
  import uprog_pkg::*;
#(
  parameter int NU   = NUM_USER,
  parameter int MAXC = MAX_CYC,
  parameter int CYW  = CY_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OP_W-1:0]  op_i,
  input  logic [CYW-1:0]   cy_i,
  input  logic             block_i,
  output logic [NU*MAXC-1:0] act_o
);

  localparam int NACT = NU * MAXC;

  logic [NACT-1:0] act_d, act_q;

  for (genvar u = 0; u < NU; u++) begin : g_user
    for (genvar c = 0; c < MAXC; c++) begin : g_cyc
      if (c < user_cycles(u)) begin : g_live
        assign act_d[u*MAXC+c] = (op_i == OP_W'(OP_USER0 + u)) && cy_i[c] && !block_i;
      end else begin : g_dead
        assign act_d[u*MAXC+c] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else         act_q <= act_d;
  end

  assign act_o = act_q;

  // R4
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act_q));

endmodule

// File: rtl/uprog_sequencer.sv
module uprog_sequencer
  import uprog_pkg::*;
#(
  parameter int PCW  = PC_W,
  parameter int NC   = NUM_COND,
  parameter int NACT = ACT_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_begin_i,
  input  logic            load_end_i,
  input  logic [NC-1:0]   cond_i,
  output logic [PCW-1:0]  pc_o,
  output logic [NACT-1:0] act_o
);

  logic [OP_W-1:0]   op;
  logic [DATA_W-1:0] data;
  logic [CY_W-1:0]   mask;
  logic [CY_W-1:0]   cy;
  logic              jump_req;
  logic              take_jump;
  logic              inc;
  logic              begin_d1;
  logic              cy_reload;
  logic              act_block;

  assign cy_reload = inc || take_jump || begin_d1;
  assign act_block = load_begin_i || load_end_i || begin_d1;

  uprog_decode #(.PCW(PCW), .NC(NC)) decode_i (
    .pc_i       (pc_o),
    .cond_i     (cond_i),
    .op_o       (op),
    .data_o     (data),
    .mask_o     (mask),
    .jump_req_o (jump_req)
  );

  uprog_pc_ctl #(.PCW(PCW), .DW(DATA_W), .CYW(CY_W), .LINES(PROG_LINES)) pc_ctl_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_begin_i (load_begin_i),
    .load_end_i   (load_end_i),
    .jump_req_i   (jump_req),
    .cy_i         (cy),
    .mask_i       (mask),
    .data_i       (data),
    .pc_o         (pc_o),
    .take_jump_o  (take_jump),
    .inc_o        (inc),
    .begin_d1_o   (begin_d1)
  );

  uprog_cycle_ctr #(.CYW(CY_W)) cycle_ctr_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reload_i (cy_reload),
    .cy_o     (cy)
  );

  uprog_action_dec #(.NU(NUM_USER), .MAXC(MAX_CYC), .CYW(CY_W)) action_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .cy_i    (cy),
    .block_i (act_block),
    .act_o   (act_o)
  );

endmodule

// File: tb/uprog_sequencer_tb.sv
module uprog_sequencer_tb_top;
  import uprog_pkg::*;

  localparam int ENDA = 9;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              lb_r, le_r;
  logic [1:0]        cond_r;
  logic [PC_W-1:0]   pc_o;
  logic [ACT_W-1:0]  act_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench's own copy of the program: opcode and target per address
  int t_op[10];
  int t_tg[10];

  // reference model state
  int m_pc, m_pos;
  bit m_parked;
  logic [ACT_W-1:0] exp_act;

  // observation bookkeeping
  int last_pc, run_cnt;
  int run_len[16];
  bit tr[16][16];
  int act_cnt[ACT_W];

  always #2.5 clk = ~clk;

  uprog_sequencer dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .load_begin_i (lb_r),
    .load_end_i   (le_r),
    .cond_i       (cond_r),
    .pc_o         (pc_o),
    .act_o        (act_o)
  );

  function automatic int op_cycles(input int op);
    if (op >= 2 && op <= 4) return op - 1;
    return 1;
  endfunction

  task automatic model_step(input logic lb, input logic le);
    int op, n;
    bit taken;
    exp_act = '0;
    if (lb) begin
      m_pc = 0; m_pos = -1; m_parked = 0;
    end else if (le) begin
      m_pc = ENDA; m_parked = 1;
    end else if (!m_parked && m_pc != ENDA) begin
      op = t_op[m_pc];
      n  = op_cycles(op);
      if (op >= 2 && op <= 4 && m_pos >= 0 && m_pos < n)
        exp_act[(op - 2) * 3 + m_pos] = 1'b1;
      if (m_pos == n) begin
        taken = (op == 1) || (op >= 5 && cond_r[op - 5]);
        m_pc  = taken ? t_tg[m_pc] : m_pc + 1;
        m_pos = 0;
      end else begin
        m_pos++;
      end
    end
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic observe();
    int p;
    p = int'(pc_o);
    if (p != last_pc) begin
      run_len[last_pc] = run_cnt;
      tr[last_pc][p]   = 1'b1;
      last_pc = p;
      run_cnt = 1;
    end else begin
      run_cnt++;
    end
    for (int i = 0; i < ACT_W; i++) if (act_o[i]) act_cnt[i]++;
  endtask

  task automatic tick(input logic lb, input logic le, input string tag);
    lb_r = lb;
    le_r = le;
    model_step(lb, le);
    @(posedge clk);
    @(negedge clk);
    observe();
    checks++;
    if (pc_o !== PC_W'(m_pc) || act_o !== exp_act) begin
      errors++;
      $display("FAIL %s pc=%0d act=%b expected pc=%0d act=%b",
               tag, pc_o, act_o, m_pc, exp_act);
    end
  endtask

  task automatic clear_obs();
    for (int i = 0; i < 16; i++) begin
      run_len[i] = 0;
      for (int j = 0; j < 16; j++) tr[i][j] = 1'b0;
    end
    for (int i = 0; i < ACT_W; i++) act_cnt[i] = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_op[0] = 2; t_tg[0] = 0;
    t_op[1] = 3; t_tg[1] = 0;
    t_op[2] = 5; t_tg[2] = 5;
    t_op[3] = 4; t_tg[3] = 0;
    t_op[4] = 1; t_tg[4] = 7;
    t_op[5] = 4; t_tg[5] = 0;
    t_op[6] = 6; t_tg[6] = 1;
    t_op[7] = 3; t_tg[7] = 0;
    t_op[8] = 0; t_tg[8] = 0;
    t_op[9] = 1; t_tg[9] = 9;

    rst_n = 1'b0; lb_r = 1'b0; le_r = 1'b0; cond_r = 2'b00;
    m_pc = ENDA; m_pos = 0; m_parked = 1; exp_act = '0;
    last_pc = ENDA; run_cnt = 0;
    clear_obs();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pc_o == PC_W'(ENDA), "R1 pc in reset", int'(pc_o), ENDA);
    check(act_o == '0, "R1 act in reset", int'(act_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pc_o == PC_W'(ENDA), "R1 pc after release", int'(pc_o), ENDA);

    // R2: end address holds itself
    repeat (6) tick(1'b0, 1'b0, "R2");

    // path with cond0 taken, cond1 not taken
    cond_r = 2'b01;
    clear_obs();
    tick(1'b1, 1'b0, "R10");
    check(pc_o == '0, "R7 pc after load-begin", int'(pc_o), 0);
    tick(1'b1, 1'b0, "R10");
    repeat (40) tick(1'b0, 1'b0, "R4");
    check(tr[2][5], "R6 cond0 taken 2->5", int'(tr[2][5]), 1);
    check(!tr[2][3], "R6 cond0 taken, 3 skipped", int'(tr[2][3]), 0);
    check(tr[6][7], "R6 cond1 not taken 6->7", int'(tr[6][7]), 1);
    check(run_len[1] == 3, "R3 U1 run length", run_len[1], 3);
    check(run_len[5] == 4, "R3 U2 run length", run_len[5], 4);
    check(run_len[8] == 2, "R3 nop run length", run_len[8], 2);
    check(act_cnt[0] == 1, "R4 U0 cycle0 pulses", act_cnt[0], 1);
    check(act_cnt[4] == 2, "R4 U1 cycle1 pulses", act_cnt[4], 2);
    check(act_cnt[5] == 0, "R4 unused slot", act_cnt[5], 0);
    check(act_cnt[8] == 1, "R4 U2 cycle2 pulses", act_cnt[8], 1);
    check(pc_o == PC_W'(ENDA), "R2 parked at end", int'(pc_o), ENDA);

    // path with cond0 not taken, unconditional jump 4->7
    cond_r = 2'b10;
    clear_obs();
    tick(1'b1, 1'b0, "R7");
    tick(1'b1, 1'b0, "R7");
    repeat (40) tick(1'b0, 1'b0, "R5");
    check(tr[2][3], "R6 cond0 not taken 2->3", int'(tr[2][3]), 1);
    check(tr[4][7], "R5 jump 4->7", int'(tr[4][7]), 1);
    check(run_len[4] == 2, "R5 jump run length", run_len[4], 2);
    check(run_len[3] == 4, "R3 U2 run length", run_len[3], 4);

    // loop via cond1, then park mid-run
    cond_r = 2'b11;
    clear_obs();
    tick(1'b1, 1'b0, "R7");
    tick(1'b1, 1'b0, "R7");
    repeat (33) tick(1'b0, 1'b0, "R6");
    check(tr[6][1], "R6 cond1 taken 6->1", int'(tr[6][1]), 1);
    tick(1'b0, 1'b1, "R9");
    check(pc_o == PC_W'(ENDA), "R9 pc after load-end", int'(pc_o), ENDA);
    tick(1'b0, 1'b1, "R9");
    repeat (8) tick(1'b0, 1'b0, "R9");

    // both commands together restart the program
    tick(1'b1, 1'b1, "R8");
    check(pc_o == '0, "R8 begin wins over end", int'(pc_o), 0);
    tick(1'b1, 1'b1, "R8");
    repeat (12) tick(1'b0, 1'b0, "R8");
    tick(1'b0, 1'b1, "R10");
    tick(1'b0, 1'b1, "R10");
    repeat (5) tick(1'b0, 1'b0, "R9");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule